// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This block produces the second operand of a 32-bit RISC data path. It takes a 12-bit operand field and an operand-form flag. With the flag low, the field describes a register operand that is shifted left, shifted right logically, shifted right arithmetically or rotated. The shift amount is either a 5-bit constant held in the field or the low byte of a second register. With the flag high, the field holds an 8-bit constant and a 4-bit rotate count. The block returns the 32-bit operand and the carry that a flag-setting instruction would copy into its carry flag.

The block does not read the register file. The caller reads the two registers that the field names and presents their values next to the field: the full value of the operand register and the low byte of the amount register. An amount of zero held in the field does not always mean "no shift". Each shift kind gives it its own meaning, and each kind has its own rule for amounts of 32 and above. When the operand register is the program counter under a register-specified amount, the value is taken 4 ahead. Naming the program counter as the amount register is flagged as an error.

Requests arrive on a valid/ready stream and results leave on one. There is one register stage between them. A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result appears with `out_valid` on the following cycle. While `out_valid` is high and `out_ready` is low, the output holds still and `in_ready` stays low, so back-pressure reaches the producer in the same cycle.

Top module: `bsh_shifter`

## Requirements
- R1: In register form (`in_imm_form`=0) the field layout is as follows. Bits 3:0 index the operand register. Bit 4 selects the amount source: 0 means constant, 1 means register. Bits 6:5 give the kind: 00 shift left, 01 logical right, 10 arithmetic right, 11 rotate right. A constant amount sits in bits 11:7. A register amount comes from `in_rs_amt`, the low byte of the register indexed by bits 11:8.
- R2: Shift left by n. For n=0 the value passes through and carry-out equals carry-in. For n=1..31 the carry is input bit 32-n. For n=32 the result is 0 and the carry is bit 0. For n>32 both the result and the carry are 0.
- R3: Logical right by n. For n=1..31 the carry is input bit n-1. A constant amount of 0 acts as n=32. For n=32 the result is 0 and the carry is bit 31. For n>32 both the result and the carry are 0.
- R4: Arithmetic right by n. For n=1..31 the carry is bit n-1. A constant amount of 0, and any n of 32 or more, fills every result bit with input bit 31 and sets the carry to bit 31.
- R5: Rotate right by a nonzero n rotates by n mod 32. The carry is bit 31 of the result.
- R6: Rotate with a constant amount of 0 rotates one place through carry. The result is {carry-in, input[31:1]} and the carry is input bit 0.
- R7: A register amount whose low byte is 0 leaves the value and the carry unchanged for all four kinds.
- R8: In constant form (`in_imm_form`=1), bits 7:0 are zero-extended and rotated right by twice bits 11:8. A rotate count of 0 returns the constant with carry = carry-in. Otherwise the carry is bit 31 of the result.
- R9: In register form with bit 4 = 1, if bits 11:8 equal 15 (the program counter), `out_error` is 1, the result is 0 and the carry equals carry-in. In every other case `out_error` is 0.
- R10: With a register amount, an operand index of 15 uses `in_rm_val`+4. With a constant amount, the operand is used unchanged.
- R11: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. The result of a request accepted on an edge appears on the next cycle. While `out_valid` is high and `out_ready` is low, all outputs hold.
- R12: While `rst_n` is low and after its release, `out_valid` is 0 until a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be taken |
| in_field | input | 12 | Operand field |
| in_imm_form | input | 1 | 1: rotated 8-bit constant, 0: shifted register |
| in_rm_val | input | 32 | Value of the operand register |
| in_rs_amt | input | 8 | Low byte of the amount register |
| in_carry | input | 1 | Current carry flag |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Shifted operand |
| out_carry | output | 1 | Shifter carry-out |
| out_error | output | 1 | Program counter used as amount register |

## Verification
The shift path is purely combinational. A wrong stage select or a wrong zero-amount decision therefore shows up in `out_result` or `out_carry` one cycle after the request is taken. The output register is the only state. A fault there shows up either as a result that changes during a stall or as a stale `out_valid`, both visible within one cycle of the stall or idle period. Amounts are drawn with a bias towards 0, 1, 31, 32, 33 and 255. These values sit on the boundaries where each shift kind changes its rule.

// File: rtl/bsh_pkg.sv
package bsh_pkg;
  localparam int SH_DW  = 32;               // operand width
  localparam int SH_AW  = 8;                // amount width
  localparam int SH_KW  = $clog2(SH_DW) + 1; // funnel shift count width (0..32)
  localparam int SH_IW  = 4;                // register index width

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } sh_kind_e;

  typedef struct packed {
    sh_kind_e              kind;
    logic [SH_AW-1:0]      amount;
    logic                  amt_is_const;
    logic [SH_DW-1:0]      value;
  } sh_req_t;
endpackage

// File: rtl/bsh_field_decode.sv
module bsh_field_decode
  import bsh_pkg::*;
#(
  parameter int PC_INDEX = 15,
  parameter int PC_AHEAD = 4
) (
  input  logic [11:0]      field,
  input  logic             imm_form,
  input  logic [SH_DW-1:0] rm_val,
  input  logic [SH_AW-1:0] rs_amt,
  output sh_req_t          req,
  output logic             err
);
  localparam logic [SH_IW-1:0] PC_IDX = SH_IW'(PC_INDEX);
  localparam logic [SH_DW-1:0] PC_ADV = SH_DW'(PC_AHEAD);

  always_comb begin
    err = 1'b0;
    req = '0;
    if (imm_form) begin
      // constant form: rotate 8-bit constant by twice the 4-bit count
      req.kind         = SH_ROR;
      req.amount       = {3'b000, field[11:8], 1'b0};
      req.amt_is_const = 1'b0;
      req.value        = {{(SH_DW-8){1'b0}}, field[7:0]};
    end else begin
      req.kind  = sh_kind_e'(field[6:5]);
      req.value = rm_val;
      if (field[4]) begin
        req.amount       = rs_amt;
        req.amt_is_const = 1'b0;
        if (field[3:0] == PC_IDX) req.value = rm_val + PC_ADV;
        if (field[11:8] == PC_IDX) err = 1'b1;
      end else begin
        req.amount       = {3'b000, field[11:7]};
        req.amt_is_const = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bsh_funnel.sv
module bsh_funnel
  import bsh_pkg::*;
#(
  parameter int DW = SH_DW
) (
  input  logic [2*DW:0]          din,
  input  logic [$clog2(DW):0]    k,
  output logic [DW:0]            dout
);
  localparam int ST   = $clog2(DW) + 1;
  localparam int LAST = 2 ** (ST - 1);

  logic [2*DW:0] stg [0:ST-1];

  assign stg[0] = din;

  for (genvar i = 0; i < ST - 1; i++) begin : g_stage
    assign stg[i+1] = k[i] ? (stg[i] >> (2 ** i)) : stg[i];
  end

  assign dout = k[ST-1] ? stg[ST-1][DW+LAST:LAST] : stg[ST-1][DW:0];
endmodule

// File: rtl/bsh_core.sv
module bsh_core
  import bsh_pkg::*;
(
  input  sh_req_t          req,
  input  logic             cin,
  output logic [SH_DW-1:0] result,
  output logic             cout
);
  localparam logic [SH_AW-1:0] FULL = SH_AW'(SH_DW);

  logic [SH_DW-1:0] rev_v, hi, sign_fill, shifted, shifted_rev;
  logic [SH_KW-1:0] k;
  logic             go_left, keep, zero_out, thru_carry;
  logic [2*SH_DW:0] fin;
  logic [SH_DW:0]   fout;

  always_comb begin
    for (int b = 0; b < SH_DW; b++) rev_v[b] = req.value[SH_DW-1-b];
    sign_fill  = {SH_DW{req.value[SH_DW-1]}};
    go_left    = 1'b0;
    keep       = 1'b0;
    zero_out   = 1'b0;
    thru_carry = 1'b0;
    hi         = '0;
    k          = '0;
    if (req.amount == '0) begin
      if (req.amt_is_const) begin
        unique case (req.kind)
          SH_LSL: keep = 1'b1;
          SH_LSR: k = SH_KW'(SH_DW);
          SH_ASR: begin k = SH_KW'(SH_DW); hi = sign_fill; end
          SH_ROR: thru_carry = 1'b1;
        endcase
      end else begin
        keep = 1'b1;
      end
    end else begin
      unique case (req.kind)
        SH_LSL: begin
          go_left = 1'b1;
          if (req.amount > FULL) zero_out = 1'b1;
          else k = req.amount[SH_KW-1:0];
        end
        SH_LSR: begin
          if (req.amount > FULL) zero_out = 1'b1;
          else k = req.amount[SH_KW-1:0];
        end
        SH_ASR: begin
          hi = sign_fill;
          k  = (req.amount >= FULL) ? SH_KW'(SH_DW) : req.amount[SH_KW-1:0];
        end
        SH_ROR: begin
          hi = req.value;
          k  = (req.amount[SH_KW-2:0] == '0) ? SH_KW'(SH_DW)
                                             : {1'b0, req.amount[SH_KW-2:0]};
        end
      endcase
    end
    fin = {hi, (go_left ? rev_v : req.value), 1'b0};
  end

  bsh_funnel #(.DW(SH_DW)) u_funnel (
    .din  (fin),
    .k    (k),
    .dout (fout)
  );

  assign shifted = fout[SH_DW:1];

  always_comb begin
    for (int b = 0; b < SH_DW; b++) shifted_rev[b] = shifted[SH_DW-1-b];
    if (keep) begin
      result = req.value;
      cout   = cin;
    end else if (zero_out) begin
      result = '0;
      cout   = 1'b0;
    end else if (thru_carry) begin
      result = {cin, req.value[SH_DW-1:1]};
      cout   = req.value[0];
    end else if (go_left) begin
      result = shifted_rev;
      cout   = fout[0];
    end else begin
      result = shifted;
      cout   = fout[0];
    end
  end
endmodule

// File: rtl/bsh_shifter.sv
module bsh_shifter
  import bsh_pkg::*;
#(
  parameter int PC_INDEX = 15,
  parameter int PC_AHEAD = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [11:0] in_field,
  input  logic        in_imm_form,
  input  logic [31:0] in_rm_val,
  input  logic [7:0]  in_rs_amt,
  input  logic        in_carry,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_result,
  output logic        out_carry,
  output logic        out_error
);
  sh_req_t          req;
  logic             dec_err;
  logic [SH_DW-1:0] core_res;
  logic             core_c;
  logic             take;

  bsh_field_decode #(.PC_INDEX(PC_INDEX), .PC_AHEAD(PC_AHEAD)) u_dec (
    .field    (in_field),
    .imm_form (in_imm_form),
    .rm_val   (in_rm_val),
    .rs_amt   (in_rs_amt),
    .req      (req),
    .err      (dec_err)
  );

  bsh_core u_core (
    .req    (req),
    .cin    (in_carry),
    .result (core_res),
    .cout   (core_c)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_carry  <= 1'b0;
      out_error  <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (take) begin
        out_error  <= dec_err;
        out_result <= dec_err ? '0 : core_res;
        out_carry  <= dec_err ? in_carry : core_c;
      end
    end
  end
endmodule

// File: rtl/bsh_shifter_chk.sv
module bsh_shifter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [11:0] in_field,
  input logic        in_imm_form,
  input logic [31:0] in_rm_val,
  input logic [7:0]  in_rs_amt,
  input logic        in_carry,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_result,
  input logic        out_carry,
  input logic        out_error
);
  logic acc, reg_src, plain_rm, plain_rs;
  assign acc      = in_valid && in_ready && !in_imm_form;
  assign reg_src  = in_field[4];
  assign plain_rm = in_field[3:0] != 4'd15;
  assign plain_rs = in_field[11:8] != 4'd15;

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> !out_valid); // R12

  AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result)
                                && $stable(out_carry) && $stable(out_error)); // R11

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R11

  AST_LSL_CONST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !reg_src && in_field[6:5] == 2'b00 && in_field[11:7] == 5'd0
    |=> out_result == $past(in_rm_val) && out_carry == $past(in_carry)); // R2

  AST_LSR_REG_32: assert property (@(posedge clk) disable iff (!rst_n)
    acc && reg_src && plain_rm && plain_rs && in_field[6:5] == 2'b01 && in_rs_amt == 8'd32
    |=> out_result == 32'd0 && out_carry == $past(in_rm_val[31])); // R3

  AST_ROT_THRU_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !reg_src && in_field[6:5] == 2'b11 && in_field[11:7] == 5'd0
    |=> out_result == {$past(in_carry), $past(in_rm_val[31:1])}
        && out_carry == $past(in_rm_val[0])); // R6

  AST_REG_AMT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    acc && reg_src && plain_rm && plain_rs && in_rs_amt == 8'd0
    |=> out_result == $past(in_rm_val) && out_carry == $past(in_carry)); // R7

  AST_CONST_ROT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_imm_form && in_field[11:8] == 4'd0
    |=> out_result == {24'd0, $past(in_field[7:0])} && out_carry == $past(in_carry)); // R8

  AST_PC_AMOUNT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    acc && reg_src && !plain_rs
    |=> out_error && out_result == 32'd0 && out_carry == $past(in_carry)); // R9
endmodule

bind bsh_shifter bsh_shifter_chk u_chk (.*);

// File: tb/bsh_shifter_bench.sv
`timescale 1ns/1ps
module bsh_shifter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_field = '0;
  logic        in_imm_form = 1'b0;
  logic [31:0] in_rm_val = '0;
  logic [7:0]  in_rs_amt = '0;
  logic        in_carry = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_carry;
  logic        out_error;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  bsh_shifter u_bsh_shifter (.*);

  function automatic logic [11:0] f_const(input logic [3:0] rm, input logic [1:0] kd,
                                          input logic [4:0] amt);
    return {amt, kd, 1'b0, rm};
  endfunction

  function automatic logic [11:0] f_reg(input logic [3:0] rm, input logic [1:0] kd,
                                        input logic [3:0] rs);
    return {rs, 1'b0, kd, 1'b1, rm};
  endfunction

  // expected {error, carry, result}
  function automatic logic [33:0] ref_model(input logic [11:0] f, input logic immf,
                                            input logic [31:0] rm, input logic [7:0] rs,
                                            input logic cin);
    logic [31:0] v, r;
    logic        c;
    int          n, m;
    if (immf) begin
      m = 2 * int'(f[11:8]);
      v = {24'd0, f[7:0]};
      r = (m == 0) ? v : ((v >> m) | (v << (32 - m)));
      c = (m == 0) ? cin : r[31];
      return {1'b0, c, r};
    end
    v = rm;
    if (f[4] && f[3:0] == 4'd15) v = rm + 32'd4;
    if (f[4] && f[11:8] == 4'd15) return {1'b1, cin, 32'd0};
    n = f[4] ? int'(rs) : int'(f[11:7]);
    r = v; c = cin;
    if (n == 0) begin
      if (!f[4]) begin
        case (f[6:5])
          2'b00: begin r = v; c = cin; end
          2'b01: begin r = 0; c = v[31]; end
          2'b10: begin r = {32{v[31]}}; c = v[31]; end
          default: begin r = {cin, v[31:1]}; c = v[0]; end
        endcase
      end
    end else begin
      case (f[6:5])
        2'b00: if (n < 32) begin r = v << n; c = v[32-n]; end
               else if (n == 32) begin r = 0; c = v[0]; end
               else begin r = 0; c = 1'b0; end
        2'b01: if (n < 32) begin r = v >> n; c = v[n-1]; end
               else if (n == 32) begin r = 0; c = v[31]; end
               else begin r = 0; c = 1'b0; end
        2'b10: if (n < 32) begin r = $unsigned($signed(v) >>> n); c = v[n-1]; end
               else begin r = {32{v[31]}}; c = v[31]; end
        default: begin
          m = n % 32;
          r = (m == 0) ? v : ((v >> m) | (v << (32 - m)));
          c = r[31];
        end
      endcase
    end
    return {1'b0, c, r};
  endfunction

  task automatic vec(input logic [11:0] f, input logic immf, input logic [31:0] rm,
                     input logic [7:0] rs, input logic cin, input string tag);
    logic [33:0] e;
    e = ref_model(f, immf, rm, rs, cin);
    @(negedge clk);
    in_field = f; in_imm_form = immf; in_rm_val = rm; in_rs_amt = rs; in_carry = cin;
    in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk); #1 in_valid = 1'b0;
    @(negedge clk);
    n_vec++;
    if (out_valid !== 1'b1 || out_result !== e[31:0] || out_carry !== e[32]
        || out_error !== e[33]) begin
      n_bad++;
      $display("FAIL %s: f=%h imm=%0b got v=%0b r=%h c=%0b e=%0b exp r=%h c=%0b e=%0b",
               tag, f, immf, out_valid, out_result, out_carry, out_error,
               e[31:0], e[32], e[33]);
    end
  endtask

  task automatic chk(input logic ok, input string tag, input logic [31:0] got,
                     input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] pick_amt();
    case ($urandom % 8)
      0: return 8'd0;
      1: return 8'd1;
      2: return 8'd31;
      3: return 8'd32;
      4: return 8'd33;
      5: return 8'd255;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [33:0] ea, eb;
    void'($urandom(32'd7321));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid === 1'b0, "R12 in reset", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R12 after reset", {31'd0, out_valid}, 32'd0);

    // R1 field decode: logical right by constant 4 from bits 11:7
    vec(f_const(4'd2, 2'b01, 5'd4), 1'b0, 32'hF000_00F0, 8'd0, 1'b0, "R1 const field");
    vec(f_reg(4'd2, 2'b10, 4'd3), 1'b0, 32'h8000_0010, 8'd5, 1'b0, "R1 reg field");
    // R2
    vec(f_const(4'd1, 2'b00, 5'd0), 1'b0, 32'h1234_5678, 8'd0, 1'b1, "R2 lsl 0");
    vec(f_const(4'd1, 2'b00, 5'd1), 1'b0, 32'h8000_0001, 8'd0, 1'b0, "R2 lsl 1");
    vec(f_const(4'd1, 2'b00, 5'd31), 1'b0, 32'h0000_0003, 8'd0, 1'b0, "R2 lsl 31");
    vec(f_reg(4'd1, 2'b00, 4'd2), 1'b0, 32'h0000_0001, 8'd32, 1'b0, "R2 lsl 32");
    vec(f_reg(4'd1, 2'b00, 4'd2), 1'b0, 32'hFFFF_FFFF, 8'd33, 1'b1, "R2 lsl 33");
    // R3
    vec(f_const(4'd1, 2'b01, 5'd0), 1'b0, 32'h8000_0000, 8'd0, 1'b0, "R3 lsr const 0");
    vec(f_const(4'd1, 2'b01, 5'd1), 1'b0, 32'h0000_0003, 8'd0, 1'b0, "R3 lsr 1");
    vec(f_reg(4'd1, 2'b01, 4'd2), 1'b0, 32'h8000_0000, 8'd32, 1'b0, "R3 lsr 32");
    vec(f_reg(4'd1, 2'b01, 4'd2), 1'b0, 32'hFFFF_FFFF, 8'd40, 1'b1, "R3 lsr 40");
    // R4
    vec(f_const(4'd1, 2'b10, 5'd0), 1'b0, 32'h8000_0000, 8'd0, 1'b0, "R4 asr const 0");
    vec(f_const(4'd1, 2'b10, 5'd31), 1'b0, 32'hC000_0000, 8'd0, 1'b0, "R4 asr 31");
    vec(f_reg(4'd1, 2'b10, 4'd2), 1'b0, 32'h8000_0001, 8'd32, 1'b0, "R4 asr 32");
    vec(f_reg(4'd1, 2'b10, 4'd2), 1'b0, 32'h7FFF_FFFF, 8'd200, 1'b1, "R4 asr 200");
    // R5
    vec(f_reg(4'd1, 2'b11, 4'd2), 1'b0, 32'h0000_0180, 8'd8, 1'b0, "R5 ror 8");
    vec(f_reg(4'd1, 2'b11, 4'd2), 1'b0, 32'h8000_0000, 8'd32, 1'b0, "R5 ror 32");
    vec(f_reg(4'd1, 2'b11, 4'd2), 1'b0, 32'h0000_0010, 8'd36, 1'b0, "R5 ror 36");
    // R6
    vec(f_const(4'd1, 2'b11, 5'd0), 1'b0, 32'h0000_0001, 8'd0, 1'b1, "R6 rrx c1");
    vec(f_const(4'd1, 2'b11, 5'd0), 1'b0, 32'hFFFF_FFFE, 8'd0, 1'b0, "R6 rrx c0");
    // R7
    for (int t = 0; t < 4; t++)
      vec(f_reg(4'd1, 2'(t), 4'd2), 1'b0, 32'h8765_4321, 8'd0, 1'(t), "R7 reg amount 0");
    // R8
    vec({4'd0, 8'hA5}, 1'b1, 32'h0, 8'd0, 1'b1, "R8 rot 0");
    vec({4'd1, 8'h03}, 1'b1, 32'h0, 8'd0, 1'b0, "R8 rot 1");
    vec({4'd15, 8'h81}, 1'b1, 32'h0, 8'd0, 1'b0, "R8 rot 15");
    // R9
    vec(f_reg(4'd1, 2'b00, 4'd15), 1'b0, 32'h1111_1111, 8'd4, 1'b1, "R9 pc amount");
    vec(f_const(4'd1, 2'b00, 5'd30), 1'b0, 32'h1111_1111, 8'd4, 1'b1, "R9 const no err");
    // R10
    vec(f_reg(4'd15, 2'b00, 4'd2), 1'b0, 32'h0000_1000, 8'd1, 1'b0, "R10 pc +4");
    vec(f_const(4'd15, 2'b00, 5'd1), 1'b0, 32'h0000_1000, 8'd0, 1'b0, "R10 pc const");

    // R11 stall and hold
    @(negedge clk); in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    ea = ref_model(f_const(4'd3, 2'b00, 5'd4), 1'b0, 32'h0000_00FF, 8'd0, 1'b0);
    eb = ref_model(f_const(4'd3, 2'b01, 5'd4), 1'b0, 32'hFF00_0000, 8'd0, 1'b0);
    out_ready = 1'b0;
    in_field = f_const(4'd3, 2'b00, 5'd4); in_imm_form = 1'b0;
    in_rm_val = 32'h0000_00FF; in_carry = 1'b0; in_valid = 1'b1;
    @(posedge clk); #1;
    in_field = f_const(4'd3, 2'b01, 5'd4); in_rm_val = 32'hFF00_0000;
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      chk(out_valid === 1'b1 && out_result === ea[31:0], "R11 hold", out_result, ea[31:0]);
      chk(in_ready === 1'b0, "R11 ready low", {31'd0, in_ready}, 32'd0);
    end
    out_ready = 1'b1;
    @(posedge clk); #1 in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b1 && out_result === eb[31:0], "R11 release", out_result, eb[31:0]);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] f;
      logic        immf;
      immf = ($urandom % 6) == 0;
      if (immf) f = 12'($urandom);
      else if ($urandom % 2) f = f_reg(4'($urandom), 2'($urandom), 4'($urandom));
      else f = f_const(4'($urandom), 2'($urandom), 5'($urandom));
      vec(f, immf, $urandom, pick_amt(), 1'($urandom), "R2-R10 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule